// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block produces the loudness contour of a single FM synthesis operator. It holds a 10-bit attenuation, where 0 is full level and 1023 is silence, and moves it through four phases: attack, decay, sustain and release. Key-on and key-off pulses start and end a note. Five-bit rate fields for attack, decay and sustain, a 4-bit sustain level, a 4-bit release field and a 5-bit key-scale offset set how fast and how far the envelope travels.

A free-running envelope counter advances on each envelope tick. Each tick, the operator takes the rate index of its current phase and reduces it to an effective rate. That rate sets a counter shift and an 8-step increment pattern, and together they decide whether the attenuation moves on that tick and by how much. A key-on chooses its starting phase from the present attenuation, the sustain level and the attack speed. Attack rates that are fast enough skip the attack phase and go straight to full level. Phase generation, low-frequency modulation, register decoding and looping envelope modes belong to other blocks.

Top module: `fmeg_envelope`

## Requirements
- R1: After reset the attenuation is 1023, the state is release (state code 3), no key is held, the envelope counter is 0 and the phase-restart output is low.
- R2: A key-on accepted while no key is held latches the key. If the attack index (0 when the attack field is 0, otherwise 32 + 2 × field, plus the key-scale offset) is below 94, the state becomes attack (code 0) when the attenuation is above 0. If the attenuation is already 0, the state becomes sustain (code 2) when the sustain field is 0, and decay (code 1) otherwise. The phase-restart output is high for the one cycle after every accepted key-on.
- R3: A key-on whose attack index is 94 or more sets the attenuation to 0 at once. The state becomes sustain when the sustain field is 0, and decay otherwise.
- R4: An attack update replaces attenuation v by v − ceil((v+1)·inc/16). When the result is 0 or below, the attenuation becomes 0 and the state becomes sustain when the sustain field is 0, and decay otherwise.
- R5: A decay update adds the increment, saturating at 1023, and moves to sustain once the attenuation is at or above the sustain level. The sustain level is 32 × field for fields 0 to 14, and 992 for field 15.
- R6: Sustain and release updates add the increment and saturate at 1023, then hold there.
- R7: The decay and sustain indices follow the same form as the attack index. The release index is 34 + 4 × release field + key-scale offset.
- R8: An index below 32 never changes the attenuation. Otherwise the effective rate r is min(index − 32, 63). The shift is 11 − r/4 for r < 48 and 0 above that. An update happens on a tick whose counter value has its low `shift` bits at zero, and the step used is bits [shift+2:shift] of that counter value. The counter then advances by one and wraps at 2^CNT_W.
- R9: Base pattern p gives an increment of 1 at odd steps, also at step 4 when p is odd, and also at steps 2 and 6 when p ≥ 2; it is 0 elsewhere. Rates 0 and 1 use increment 0. Rates 2 to 5 use p = 0 and rates 6 and 7 use p = 2. Rates 8 to 47 use p = r mod 4. Rates 48 to 59 use 2^((r−48)/4) × (1 + h), where h is 0 for p = 0; 1 at steps 3 and 7 for p = 1; 1 at odd steps for p = 2; and 1 at steps not divisible by 4 for p = 3, with p = r mod 4. Rates 60 to 63 add 8.
- R10: A sustain-level write strobe while in decay, with the attenuation at or above the new level, moves the state to sustain at that clock edge and skips that cycle's update.
- R11: A key-off while a key is held moves the state to release. A key-off with no key held, or a key-on while a key is held, changes nothing. A key-on takes priority over a key-off, and both take priority over the sustain-write check and the rate update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eg_tick_i | input | 1 | Envelope tick; advances the envelope counter and allows an update |
| key_on_i | input | 1 | Key-on pulse |
| key_off_i | input | 1 | Key-off pulse |
| sl_wr_i | input | 1 | Strobe marking a write of the sustain level |
| attack_rate_i | input | 5 | Attack rate field |
| decay_rate_i | input | 5 | Decay rate field |
| sustain_rate_i | input | 5 | Sustain rate field |
| sustain_lvl_i | input | 4 | Sustain level field |
| release_rate_i | input | 4 | Release rate field |
| ks_offset_i | input | 5 | Key-scale offset added to every rate index |
| atten_o | output | 10 | Current attenuation (0 is loudest) |
| state_o | output | 2 | Envelope phase: 0 attack, 1 decay, 2 sustain, 3 release |
| phase_rst_o | output | 1 | One-cycle pulse after an accepted key-on |

## Verification
A wrong phase shows up on `state_o` at the very next clock edge. A wrong attenuation step shows up on `atten_o` at the first tick whose counter bits select an update. At fast rates that is within one or two cycles; at the slowest finite rate it can take up to 2048 ticks. A wrong counter phase or a wrong pattern entry therefore only shows as a drift that builds up over many updates. For this reason the reference model is compared on every cycle, not only at the end points, and the runs include fast rates, where each tick counts.

// File: rtl/fmeg_pkg.sv
package fmeg_pkg;
  localparam int ATT_W        = 10;
  localparam int IDX_W        = 7;
  localparam int FAST_ATK_IDX = 94;
  localparam int FINITE_BASE  = 32;
  localparam int SLOW_SHIFT   = 11;
  localparam logic [ATT_W-1:0] ATT_MAX = '1;

  typedef enum logic [1:0] {
    ST_ATK = 2'd0,
    ST_DEC = 2'd1,
    ST_SUS = 2'd2,
    ST_REL = 2'd3
  } env_state_e;

  // index for attack, decay and sustain fields
  function automatic logic [IDX_W-1:0] rate_idx(input logic [4:0] field,
                                                input logic [4:0] ks);
    logic [IDX_W-1:0] base;
    base = (field == 5'd0) ? '0 : IDX_W'(FINITE_BASE) + {1'b0, field, 1'b0};
    return base + IDX_W'(ks);
  endfunction

  function automatic logic [IDX_W-1:0] rel_idx(input logic [3:0] field,
                                               input logic [4:0] ks);
    return IDX_W'(34) + {1'b0, field, 2'b00} + IDX_W'(ks);
  endfunction

  function automatic logic [5:0] eff_rate(input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] d;
    d = idx - IDX_W'(FINITE_BASE);
    return (d > IDX_W'(63)) ? 6'd63 : d[5:0];
  endfunction

  function automatic logic [3:0] rate_shift(input logic [5:0] r);
    return (r < 6'd48) ? 4'(4'd11 - r[5:2]) : 4'd0;
  endfunction

  function automatic logic [ATT_W-1:0] level_of(input logic [3:0] sl);
    return (sl == 4'd15) ? ATT_W'(992) : ATT_W'({sl, 5'b00000});
  endfunction

  function automatic logic [3:0] pat_inc(input logic [5:0] r, input logic [2:0] s);
    logic [1:0] p;
    logic       lo;
    logic       hi;
    logic [1:0] k;
    p = r[1:0];
    if (r < 6'd6) p = 2'd0;
    else if (r < 6'd8) p = 2'd2;
    lo = s[0] | ((s == 3'd4) & p[0]) | (((s == 3'd2) | (s == 3'd6)) & p[1]);
    case (p)
      2'd0:    hi = 1'b0;
      2'd1:    hi = s[1] & s[0];
      2'd2:    hi = s[0];
      default: hi = (s[1:0] != 2'd0);
    endcase
    k = 2'(r[5:2] - 4'd12);
    if (r < 6'd2)        return 4'd0;
    else if (r < 6'd48)  return {3'b000, lo};
    else if (r >= 6'd60) return 4'd8;
    else                 return (4'd1 << k) << hi;
  endfunction

  // v - ceil((v+1)*inc/16), floored at zero
  function automatic logic [ATT_W-1:0] attack_next(input logic [ATT_W-1:0] v,
                                                   input logic [3:0] inc);
    logic [14:0] prod;
    logic [10:0] dec;
    prod = (15'(v) + 15'd1) * 15'(inc) + 15'd15;
    dec  = prod[14:4];
    return (dec >= 11'(v)) ? '0 : ATT_W'(11'(v) - dec);
  endfunction
endpackage

// File: rtl/fmeg_tick_counter.sv
module fmeg_tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fmeg_rate_unit.sv
module fmeg_rate_unit
  import fmeg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  env_state_e       state_i,
  input  logic [4:0]       ar_i,
  input  logic [4:0]       dr_i,
  input  logic [4:0]       sr_i,
  input  logic [3:0]       rr_i,
  input  logic [4:0]       ks_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             step_en_o,
  output logic [3:0]       inc_o,
  output logic             fast_atk_o
);
  logic [IDX_W-1:0] atk_idx;
  logic [IDX_W-1:0] sel_idx;
  logic             finite;
  logic [5:0]       rate;
  logic [3:0]       shamt;
  logic [CNT_W-1:0] low_mask;
  logic [2:0]       step;

  always_comb begin
    atk_idx = rate_idx(ar_i, ks_i);
    unique case (state_i)
      ST_ATK:  sel_idx = atk_idx;
      ST_DEC:  sel_idx = rate_idx(dr_i, ks_i);
      ST_SUS:  sel_idx = rate_idx(sr_i, ks_i);
      default: sel_idx = rel_idx(rr_i, ks_i);
    endcase
    finite    = (sel_idx >= IDX_W'(FINITE_BASE));
    rate      = eff_rate(sel_idx);
    shamt     = finite ? rate_shift(rate) : 4'(SLOW_SHIFT);
    low_mask  = (CNT_W'(1) << shamt) - CNT_W'(1);
    step      = 3'(cnt_i >> shamt);
    step_en_o = tick_i && finite && ((cnt_i & low_mask) == '0);
    inc_o     = finite ? pat_inc(rate, step) : 4'd0;
  end

  assign fast_atk_o = (atk_idx >= IDX_W'(FAST_ATK_IDX));
endmodule

// File: rtl/fmeg_env_core.sv
module fmeg_env_core
  import fmeg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_on_i,
  input  logic             key_off_i,
  input  logic             sl_wr_i,
  input  logic [3:0]       sl_i,
  input  logic             fast_atk_i,
  input  logic             step_en_i,
  input  logic [3:0]       inc_i,
  output logic [ATT_W-1:0] atten_o,
  output env_state_e       state_o,
  output logic             phase_rst_o,
  output logic             keyon_evt_o,
  output logic             keyoff_evt_o,
  output logic             sl_hit_o
);
  logic             held_q;
  logic             held_d;
  logic [ATT_W-1:0] atten_d;
  env_state_e       state_d;
  logic [ATT_W-1:0] lvl;
  logic [ATT_W:0]   added;
  logic [ATT_W-1:0] sat_add;
  logic [ATT_W-1:0] atk_val;
  env_state_e       settle_st;

  assign lvl          = level_of(sl_i);
  assign settle_st    = (sl_i == 4'd0) ? ST_SUS : ST_DEC;
  assign keyon_evt_o  = key_on_i && !held_q;
  assign keyoff_evt_o = key_off_i && held_q;
  assign sl_hit_o     = sl_wr_i && (state_o == ST_DEC) && (atten_o >= lvl);
  assign added        = {1'b0, atten_o} + (ATT_W+1)'(inc_i);
  assign sat_add      = added[ATT_W] ? ATT_MAX : added[ATT_W-1:0];
  assign atk_val      = attack_next(atten_o, inc_i);

  always_comb begin
    atten_d = atten_o;
    state_d = state_o;
    held_d  = held_q;
    if (keyon_evt_o) begin
      held_d = 1'b1;
      if (fast_atk_i) begin
        atten_d = '0;
        state_d = settle_st;
      end else begin
        state_d = (atten_o != '0) ? ST_ATK : settle_st;
      end
    end else if (keyoff_evt_o) begin
      held_d  = 1'b0;
      state_d = ST_REL;
    end else if (sl_hit_o) begin
      state_d = ST_SUS;
    end else if (step_en_i) begin
      unique case (state_o)
        ST_ATK: begin
          atten_d = atk_val;
          if (atk_val == '0) state_d = settle_st;
        end
        ST_DEC: begin
          atten_d = sat_add;
          if (sat_add >= lvl) state_d = ST_SUS;
        end
        default: atten_d = sat_add;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atten_o     <= ATT_MAX;
      state_o     <= ST_REL;
      held_q      <= 1'b0;
      phase_rst_o <= 1'b0;
    end else begin
      atten_o     <= atten_d;
      state_o     <= state_d;
      held_q      <= held_d;
      phase_rst_o <= keyon_evt_o;
    end
  end
endmodule

// File: rtl/fmeg_envelope.sv
module fmeg_envelope
  import fmeg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eg_tick_i,
  input  logic         key_on_i,
  input  logic         key_off_i,
  input  logic         sl_wr_i,
  input  logic [4:0]   attack_rate_i,
  input  logic [4:0]   decay_rate_i,
  input  logic [4:0]   sustain_rate_i,
  input  logic [3:0]   sustain_lvl_i,
  input  logic [3:0]   release_rate_i,
  input  logic [4:0]   ks_offset_i,
  output logic [9:0]   atten_o,
  output logic [1:0]   state_o
  ,
  output logic         phase_rst_o
);
  logic [CNT_W-1:0] env_cnt;
  logic             step_en;
  logic [3:0]       step_inc;
  logic             fast_atk;
  logic             keyon_evt;
  logic             keyoff_evt;
  logic             sl_hit;
  env_state_e       cur_state;
  logic [ATT_W-1:0] cur_atten;

  fmeg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (eg_tick_i),
    .cnt_o  (env_cnt)
  );

  fmeg_rate_unit #(.CNT_W(CNT_W)) u_rate (
    .state_i    (cur_state),
    .ar_i       (attack_rate_i),
    .dr_i       (decay_rate_i),
    .sr_i       (sustain_rate_i),
    .rr_i       (release_rate_i),
    .ks_i       (ks_offset_i),
    .cnt_i      (env_cnt),
    .tick_i     (eg_tick_i),
    .step_en_o  (step_en),
    .inc_o      (step_inc),
    .fast_atk_o (fast_atk)
  );

  fmeg_env_core u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_on_i     (key_on_i),
    .key_off_i    (key_off_i),
    .sl_wr_i      (sl_wr_i),
    .sl_i         (sustain_lvl_i),
    .fast_atk_i   (fast_atk),
    .step_en_i    (step_en),
    .inc_i        (step_inc),
    .atten_o      (cur_atten),
    .state_o      (cur_state),
    .phase_rst_o  (phase_rst_o),
    .keyon_evt_o  (keyon_evt),
    .keyoff_evt_o (keyoff_evt),
    .sl_hit_o     (sl_hit)
  );

  assign atten_o = cur_atten;
  assign state_o = cur_state;
endmodule

// File: rtl/fmeg_env_checks.sv
module fmeg_env_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       keyon_evt,
  input logic       keyoff_evt,
  input logic       sl_hit,
  input logic       step_en,
  input logic       fast_atk,
  input logic [9:0] atten,
  input logic [1:0] state,
  input logic       phase_rst
);
  p_fast_keyon_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (keyon_evt && fast_atk) |=> (atten == 10'd0) && (state != 2'd0));

  p_phase_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    keyon_evt |=> phase_rst);

  p_phase_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase_rst |-> $past(keyon_evt));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!keyon_evt && !step_en) |=> $stable(atten));

  p_attack_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 2'd0 && !keyon_evt) |=> (state != 2'd0));

  p_release_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd3 && !keyon_evt) |=> (state == 2'd3) && (atten >= $past(atten)));

  p_sl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_hit && !keyon_evt && !keyoff_evt) |=> (state == 2'd2));
endmodule

bind fmeg_envelope fmeg_env_checks u_env_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .keyon_evt  (keyon_evt),
  .keyoff_evt (keyoff_evt),
  .sl_hit     (sl_hit),
  .step_en    (step_en),
  .fast_atk   (fast_atk),
  .atten      (atten_o),
  .state      (state_o),
  .phase_rst  (phase_rst_o)
);

// File: tb/test_fmeg_envelope.sv
`timescale 1ns/1ps
module test_fmeg_envelope;
  localparam int ATK = 0, DEC = 1, SUS = 2, REL = 3;
  localparam int CNT_MOD = 65536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, kon = 1'b0, koff = 1'b0, slw = 1'b0;
  logic [4:0] ar = '0, dr = '0, sr = '0, ks = '0;
  logic [3:0] sl = '0, rr = '0;
  logic [9:0] atten;
  logic [1:0] state;
  logic       prst;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_att = 1023, m_st = REL, m_cnt = 0;
  bit m_held = 0, m_prst = 0;
  string m_tag = "R1";

  int lo_tab [4][8] = '{'{0,1,0,1,0,1,0,1}, '{0,1,0,1,1,1,0,1},
                        '{0,1,1,1,0,1,1,1}, '{0,1,1,1,1,1,1,1}};
  int hi_tab [4][8] = '{'{1,1,1,1,1,1,1,1}, '{1,1,1,2,1,1,1,2},
                        '{1,2,1,2,1,2,1,2}, '{1,2,2,2,1,2,2,2}};

  always #5 clk = ~clk;

  fmeg_envelope i_fmeg_envelope (
    .clk(clk), .rst_n(rst_n), .eg_tick_i(tick), .key_on_i(kon), .key_off_i(koff),
    .sl_wr_i(slw), .attack_rate_i(ar), .decay_rate_i(dr), .sustain_rate_i(sr),
    .sustain_lvl_i(sl), .release_rate_i(rr), .ks_offset_i(ks),
    .atten_o(atten), .state_o(state), .phase_rst_o(prst)
  );

  function automatic int m_idx(int f, int k);
    return ((f == 0) ? 0 : 32 + 2 * f) + k;
  endfunction

  function automatic int m_lvl(int s);
    return (s == 15) ? 992 : s * 32;
  endfunction

  function automatic int m_inc(int r, int s);
    if (r < 2)  return 0;
    if (r < 6)  return lo_tab[0][s];
    if (r < 8)  return lo_tab[2][s];
    if (r < 48) return lo_tab[r % 4][s];
    if (r < 60) return hi_tab[r % 4][s] * (1 << ((r - 48) / 4));
    return 8;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int cc, idx, r, sh, s, inc, lvl, nv, settle;
    cc = m_cnt;
    if (tick) m_cnt = (m_cnt + 1) % CNT_MOD;
    m_prst = 0;
    lvl = m_lvl(int'(sl));
    settle = (sl == 0) ? SUS : DEC;
    m_tag = "R8";
    if (kon && !m_held) begin
      m_held = 1; m_prst = 1;
      if (m_idx(int'(ar), int'(ks)) >= 94) begin
        m_att = 0; m_st = settle; m_tag = "R3";
      end else begin
        m_st = (m_att > 0) ? ATK : settle; m_tag = "R2";
      end
    end else if (koff && m_held) begin
      m_held = 0; m_st = REL; m_tag = "R11";
    end else if (slw && m_st == DEC && m_att >= lvl) begin
      m_st = SUS; m_tag = "R10";
    end else if (tick) begin
      case (m_st)
        ATK:     idx = m_idx(int'(ar), int'(ks));
        DEC:     idx = m_idx(int'(dr), int'(ks));
        SUS:     idx = m_idx(int'(sr), int'(ks));
        default: idx = 34 + 4 * int'(rr) + int'(ks);
      endcase
      if (idx >= 32) begin
        r  = (idx - 32 > 63) ? 63 : idx - 32;
        sh = (r < 48) ? 11 - r / 4 : 0;
        if (cc % (1 << sh) == 0) begin
          s = (cc >> sh) % 8;
          inc = m_inc(r, s);
          m_tag = "R9";
          case (m_st)
            ATK: begin
              nv = m_att - ((m_att + 1) * inc + 15) / 16;
              if (nv <= 0) begin m_att = 0; m_st = settle; end
              else m_att = nv;
            end
            DEC: begin
              nv = m_att + inc; if (nv > 1023) nv = 1023;
              m_att = nv;
              if (nv >= lvl) m_st = SUS;
            end
            default: begin
              nv = m_att + inc; if (nv > 1023) nv = 1023;
              m_att = nv;
            end
          endcase
        end
      end
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    chk(int'(atten) == m_att, m_tag, "atten", int'(atten), m_att);
    chk(int'(state) == m_st, m_tag, "state", int'(state), m_st);
    chk(prst == m_prst, "R2", "phase_rst", int'(prst), int'(m_prst));
  endtask

  task automatic pulse_keyon();
    kon = 1; cyc(); kon = 0;
  endtask

  task automatic pulse_keyoff();
    koff = 1; cyc(); koff = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int guard;
    repeat (3) @(negedge clk);
    chk(atten == 10'd1023, "R1", "reset atten", int'(atten), 1023);
    chk(state == 2'd3, "R1", "reset state", int'(state), 3);
    chk(prst == 1'b0, "R1", "reset phase", int'(prst), 0);
    rst_n = 1;
    cyc();

    // fast attack: index 32+62+31 = 125
    ar = 31; ks = 31; sl = 0; rr = 15; dr = 0; sr = 0;
    pulse_keyon();
    chk(atten == 0, "R3", "fast key-on atten", int'(atten), 0);
    chk(state == 2'd2, "R3", "fast key-on state", int'(state), 2);
    chk(prst == 1'b1, "R2", "phase pulse", int'(prst), 1);
    pulse_keyon();
    chk(prst == 1'b0, "R11", "key-on while held no pulse", int'(prst), 0);
    chk(state == 2'd2, "R11", "key-on while held state", int'(state), 2);

    // sustain index = ks = 31 is infinite
    tick = 1;
    repeat (20) cyc();
    chk(atten == 0, "R8", "infinite rate holds", int'(atten), 0);

    // release at rate 63 saturates
    pulse_keyoff();
    chk(state == 2'd3, "R11", "key-off to release", int'(state), 3);
    repeat (200) cyc();
    chk(atten == 10'd1023, "R6", "release saturates", int'(atten), 1023);
    pulse_keyoff();
    chk(state == 2'd3, "R11", "key-off without key", int'(state), 3);

    // slow attack then decay to level 96
    ks = 0; ar = 20; dr = 20; sl = 3; sr = 0;
    pulse_keyon();
    chk(state == 2'd0, "R2", "slow key-on enters attack", int'(state), 0);
    guard = 0;
    while (state == 2'd0 && guard < 40000) begin cyc(); guard++; end
    chk(atten == 0, "R4", "attack ends at zero", int'(atten), 0);
    chk(state == 2'd1, "R4", "attack to decay", int'(state), 1);
    guard = 0;
    while (state == 2'd1 && guard < 40000) begin cyc(); guard++; end
    chk(state == 2'd2, "R5", "decay reaches sustain", int'(state), 2);
    chk(atten >= 96 && atten < 100, "R5", "decay stop level", int'(atten), 96);

    // sustain-level write in decay
    tick = 0;
    pulse_keyoff();
    ar = 31; ks = 31; sl = 10; dr = 1;
    pulse_keyon();
    chk(state == 2'd1, "R3", "fast key-on into decay", int'(state), 1);
    sl = 5; slw = 1; cyc(); slw = 0;
    chk(state == 2'd1, "R10", "write above atten stays", int'(state), 1);
    sl = 0; slw = 1; cyc(); slw = 0;
    chk(state == 2'd2, "R10", "write at atten to sustain", int'(state), 2);

    // slow key-on at zero attenuation goes straight to sustain
    pulse_keyoff();
    ks = 0; ar = 5; rr = 0;
    pulse_keyon();
    chk(state == 2'd2, "R2", "key-on at zero skips attack", int'(state), 2);
    chk(atten == 0, "R7", "release index 34 slow", int'(atten), 0);

    // free-running mixed traffic, compared every cycle
    for (int i = 0; i < 12000; i++) begin
      if (i % 300 == 0) begin
        ar = 5'($urandom); dr = 5'($urandom); sr = 5'($urandom);
        rr = 4'($urandom); ks = 5'($urandom % 32); sl = 4'($urandom);
      end
      tick = ($urandom % 4) != 0;
      kon  = ($urandom % 211) == 0;
      koff = ($urandom % 173) == 0;
      slw  = ($urandom % 61) == 0;
      if (slw) sl = 4'($urandom);
      cyc();
    end
    kon = 0; koff = 0; slw = 0; tick = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule